// File: doc/BRIEF.md
# Accumulator ALU with status flags

A purely combinational arithmetic and logic unit for a small 8-bit processor datapath. It takes the accumulator value, one operand byte, the current flag word and a 4-bit operation code, and produces a result byte, a write strobe for the accumulator and the next flag word. The surrounding control logic registers the flags and writes the result back.

The unit performs add, add with carry, subtract, compare, AND, OR, XOR, increment, decrement and four accumulator rotates. Two of the rotates are plain and two go through the carry flag. Compare changes only the flags. Increment and decrement act on the operand and return it for write-back to wherever the operand came from, so they do not strobe the accumulator. Carry means borrow after subtract and compare.

Flag word layout, used on both `flg_i` and `flg_o`: bit 3 Sign, bit 2 Zero, bit 1 Parity, bit 0 Carry.

Top module: `acc_alu`

## Requirements
- R1: Code 0 (add) and code 1 (add with carry) put the low 8 bits of acc+opnd (+ incoming carry for code 1) on the result, assert the accumulator strobe, and set Carry to the ninth bit of the sum.
- R2: Code 2 (subtract) puts (acc-opnd) mod 256 on the result in two's complement, asserts the strobe, and sets Carry when acc < opnd (borrow).
- R3: Code 3 (compare) leaves the result equal to acc and the strobe low, sets Carry exactly when acc < opnd and Zero exactly when acc == opnd, and sets Sign and Parity from acc-opnd.
- R4: Codes 4, 5 and 6 (AND, OR, XOR) put the bitwise result on the result, assert the strobe and clear Carry.
- R5: Codes 7 (increment) and 8 (decrement) put opnd+1 and opnd-1 (mod 256) on the result, keep the strobe low and pass Carry through unchanged.
- R6: Code 9 rotates acc left, with bit 7 entering bit 0. Code 10 rotates acc right, with bit 0 entering bit 7. In both cases Carry takes the bit rotated out and the strobe is asserted.
- R7: Code 11 rotates acc left through carry: bit 7 goes to Carry and the old Carry goes to bit 0. Code 12 rotates acc right through carry: bit 0 goes to Carry and the old Carry goes to bit 7. The strobe is asserted.
- R8: The four rotates pass Sign, Zero and Parity through unchanged.
- R9: For codes 0 to 8, Sign is result bit 7 (for compare, bit 7 of the difference), Zero is set for a zero value, and Parity is set when the number of 1 bits is even.
- R10: Codes 13 to 15 put acc on the result, keep the strobe low and return the flag word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Operand byte |
| flg_i | input | 4 | Current flags {S,Z,P,C} |
| res_o | output | 8 | Result byte |
| acc_we_o | output | 1 | Accumulator write strobe |
| flg_o | output | 4 | Next flags {S,Z,P,C} |

## Verification
The unit holds no state, so any internal fault shows at the ports in the same evaluation as the inputs that trigger it. A result, strobe or flag bit that is wrong appears at once for the operation code that selects the faulty path. The bench therefore compares every output word for each applied vector. The carry-in and borrow paths show only when the incoming carry is set or acc < opnd, so directed vectors cover these values alongside random ones.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic [3:0]   flg_i,
  output logic [W-1:0] res_o,
  output logic         acc_we_o,
  output logic [3:0]   flg_o
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_CMP = 4'd3,
                         OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_INC = 4'd7,
                         OP_DEC = 4'd8, OP_RLC = 4'd9, OP_RRC = 4'd10, OP_RAL = 4'd11,
                         OP_RAR = 4'd12;

  logic         cy_in;
  logic [W:0]   sum;
  logic [W:0]   dif;
  logic [W-1:0] val;
  logic         cy_nx;
  logic         szp_upd;

  assign cy_in = flg_i[0];
  assign sum   = {1'b0, acc_i} + {1'b0, opnd_i} + {{W{1'b0}}, (op == OP_ADC) & cy_in};
  assign dif   = {1'b0, acc_i} - {1'b0, opnd_i};

  always_comb begin
    res_o    = acc_i;
    val      = acc_i;
    acc_we_o = 1'b0;
    cy_nx    = cy_in;
    szp_upd  = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        res_o = sum[W-1:0]; val = res_o; acc_we_o = 1'b1; cy_nx = sum[W]; szp_upd = 1'b1;
      end
      OP_SUB: begin
        res_o = dif[W-1:0]; val = res_o; acc_we_o = 1'b1; cy_nx = dif[W]; szp_upd = 1'b1;
      end
      OP_CMP: begin
        val = dif[W-1:0]; cy_nx = dif[W]; szp_upd = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_o = (op == OP_AND) ? (acc_i & opnd_i) :
                (op == OP_OR)  ? (acc_i | opnd_i) : (acc_i ^ opnd_i);
        val = res_o; acc_we_o = 1'b1; cy_nx = 1'b0; szp_upd = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res_o = (op == OP_INC) ? opnd_i + 1'b1 : opnd_i - 1'b1;
        val = res_o; szp_upd = 1'b1;
      end
      OP_RLC: begin
        res_o = {acc_i[W-2:0], acc_i[W-1]}; acc_we_o = 1'b1; cy_nx = acc_i[W-1];
      end
      OP_RRC: begin
        res_o = {acc_i[0], acc_i[W-1:1]}; acc_we_o = 1'b1; cy_nx = acc_i[0];
      end
      OP_RAL: begin
        res_o = {acc_i[W-2:0], cy_in}; acc_we_o = 1'b1; cy_nx = acc_i[W-1];
      end
      OP_RAR: begin
        res_o = {cy_in, acc_i[W-1:1]}; acc_we_o = 1'b1; cy_nx = acc_i[0];
      end
      default: ;
    endcase
  end

  assign flg_o = szp_upd ? {val[W-1], ~|val, ~^val, cy_nx} : {flg_i[3:1], cy_nx};

  always_comb begin
    if (op == OP_CMP) begin
      AST_CMP_NO_WRITE: assert (!acc_we_o && res_o == acc_i);                 // R3
      AST_CMP_FLAGS: assert (flg_o[0] == (acc_i < opnd_i) && flg_o[2] == (acc_i == opnd_i)); // R3
    end
    if (op == OP_AND || op == OP_OR || op == OP_XOR)
      AST_LOGIC_CY_CLEAR: assert (!flg_o[0] && acc_we_o);                      // R4
    if (op == OP_INC || op == OP_DEC)
      AST_STEP_CY_HOLD: assert (flg_o[0] == flg_i[0] && !acc_we_o);            // R5
    if (op >= OP_RLC && op <= OP_RAR)
      AST_ROT_SZP_HOLD: assert (flg_o[3:1] == flg_i[3:1]);                     // R8
    if (op > OP_RAR)
      AST_PASS_IDLE: assert (flg_o == flg_i && !acc_we_o && res_o == acc_i);   // R10
  end
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  localparam int PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] op = 4'd15;
  logic [W-1:0] acc_i = '0, opnd_i = '0;
  logic [3:0] flg_i = '0;
  logic [W-1:0] res_o;
  logic acc_we_o;
  logic [3:0] flg_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [12:0] exp_q[$];
  logic [3:0]  op_q[$];

  acc_alu #(.W(W)) u_acc_alu (.op(op), .acc_i(acc_i), .opnd_i(opnd_i), .flg_i(flg_i),
                              .res_o(res_o), .acc_we_o(acc_we_o), .flg_o(flg_o));

  always #(PERIOD/2) clk = ~clk;

  function automatic string tag(input logic [3:0] o);
    case (o)
      0, 1: return "R1";
      2: return "R2";
      3: return "R3";
      4, 5, 6: return "R4";
      7, 8: return "R5";
      9, 10: return "R6/R8";
      11, 12: return "R7/R8";
      default: return "R10";
    endcase
  endfunction

  function automatic bit even_ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2) == 0;
  endfunction

  function automatic logic [12:0] model(input int o, input int a, input int b, input int f);
    int r = a, v = a, c = f & 1, we = 0, upd = 0;
    case (o)
      0: begin v = a + b; c = v > 255; v &= 255; r = v; we = 1; upd = 1; end
      1: begin v = a + b + (f & 1); c = v > 255; v &= 255; r = v; we = 1; upd = 1; end
      2: begin v = (a - b + 256) % 256; c = a < b; r = v; we = 1; upd = 1; end
      3: begin v = (a - b + 256) % 256; c = a < b; upd = 1; end
      4: begin r = a & b; v = r; c = 0; we = 1; upd = 1; end
      5: begin r = a | b; v = r; c = 0; we = 1; upd = 1; end
      6: begin r = a ^ b; v = r; c = 0; we = 1; upd = 1; end
      7: begin r = (b + 1) % 256; v = r; upd = 1; end
      8: begin r = (b + 255) % 256; v = r; upd = 1; end
      9: begin c = a / 128; r = (a * 2) % 256 + c; we = 1; end
      10: begin c = a % 2; r = a / 2 + c * 128; we = 1; end
      11: begin r = (a * 2) % 256 + (f & 1); c = a / 128; we = 1; end
      12: begin r = a / 2 + (f & 1) * 128; c = a % 2; we = 1; end
      default: ;
    endcase
    if (upd != 0)
      return {r[7:0], we[0], v[7] == 1'b1, v == 0, even_ones(v), c[0]};
    return {r[7:0], we[0], f[3:1], c[0]};
  endfunction

  task automatic drive(input int o, input int a, input int b, input int f);
    @(negedge clk);
    op = o[3:0]; acc_i = a[7:0]; opnd_i = b[7:0]; flg_i = f[3:0];
    exp_q.push_back(model(o, a, b, f));
    op_q.push_back(o[3:0]);
  endtask

  always @(posedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      logic [12:0] e;
      logic [12:0] g;
      logic [3:0]  o;
      e = exp_q.pop_front();
      o = op_q.pop_front();
      g = {res_o, acc_we_o, flg_o};
      checks++;
      if (g !== e) begin
        errors++;
        if (o <= 8 && g[3:1] !== e[3:1])
          $display("FAIL R9 op=%0d got=%h exp=%h", o, g, e);
        else
          $display("FAIL %s op=%0d got=%h exp=%h", tag(o), o, g, e);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // idle state after reset: pass-through code, R10
    drive(15, 0, 0, 0);
    drive(13, 8'h5A, 8'h11, 4'hB);
    // R1 carry out and carry in
    drive(0, 8'h80, 8'h80, 0);
    drive(1, 8'hFF, 8'h00, 1);
    drive(1, 8'h10, 8'h20, 0);
    // R2 negative result, borrow
    drive(2, 8'h05, 8'h07, 0);
    // R3 less, equal, greater
    drive(3, 8'h10, 8'h20, 0);
    drive(3, 8'h33, 8'h33, 1);
    drive(3, 8'h40, 8'h20, 1);
    // R4 carry cleared
    drive(4, 8'hF0, 8'h0F, 1);
    drive(6, 8'hAA, 8'hAA, 1);
    // R5 wrap with carry held
    drive(7, 0, 8'hFF, 1);
    drive(8, 0, 8'h00, 0);
    // R6, R7, R8 rotates
    drive(9, 8'h81, 0, 4'hE);
    drive(10, 8'h01, 0, 4'h0);
    drive(11, 8'h80, 0, 4'h1);
    drive(12, 8'h01, 0, 4'h8);
    // random sweep over all codes, R9 flag rules included
    for (int k = 0; k < 3000; k++)
      drive(k % 16, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 15));
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule